// File: doc/BRIEF.md
# Header Streamer with Aligned Payload Merge

This block turns one packet's assembled header region and its payload stream into a single byte-contiguous output stream on a bus of `BUS_BYTES` bytes. A packet is launched with a start strobe that carries the header buffer, the header length in bytes, the header word count used as the payload release delay, and the payload alignment offset. Header words then leave one per cycle, and the payload joins them with no gap.

Payload words enter a small delay line. The delay line gives back-pressure when it is full, so payload can arrive before the packet is launched. If the header length is not a whole number of bus words, the trailing header bytes are held as a carry. The same shift then applies to every payload word, so each output word takes the carry followed by the leading bytes of the next payload word. If that shift pushes the final payload bytes past a word boundary, one extra trailing word is emitted. The final output word reports how many of its bytes are valid.

Byte 0 of every word (header buffer, payload and output) sits in the most significant byte lane. The header buffer holds byte 0 in its top eight bits.

Top module: `hdr_streamer`

## Requirements
- R1: A start is accepted only in a cycle where `start_ready_o` is high. After an accepted start, `start_ready_o` stays low until the packet's last word has left, and start strobes offered in that time have no effect on the output stream.
- R2: Header bytes are emitted in order, byte 0 first in the top byte lane. Each complete header word takes one cycle, beginning in the cycle after the start is accepted.
- R3: `delay_i` must equal the header word count ceil(`hdr_len_i` / BUS_BYTES). The block emits `delay_i` header words when `align_i` is 0 and `delay_i` − 1 complete header words otherwise, and then begins releasing payload.
- R4: `align_i` must equal (BUS_BYTES − `hdr_len_i` mod BUS_BYTES) mod BUS_BYTES. When it is nonzero, the word holding the final header bytes carries BUS_BYTES − `align_i` header bytes followed by the first `align_i` payload bytes.
- R5: After the boundary word, the output holds payload only, shifted by the same offset, with leftover bytes carried into the next word. Output is one word per cycle and has no idle cycle while the delay line holds data.
- R6: Every output word that is not the last has `out_cnt_o` = BUS_BYTES. The last word has `out_last_o` = 1 and `out_cnt_o` in 1..BUS_BYTES. `pay_cnt_i` (1..BUS_BYTES, BUS_BYTES meaning full) gives the valid bytes of the final payload word.
- R7: If the carried bytes plus the final payload word's count exceed BUS_BYTES, an extra word follows with the remaining count and the last flag. Otherwise the merged word is itself last, with the summed count.
- R8: `pay_ready_o` is low while the delay line holds DEPTH words, and a payload word offered then is not taken.
- R9: After reset, `out_valid_o` is low and both `start_ready_o` and `pay_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Packet launch strobe |
| start_ready_o | output | 1 | Block idle, start can be taken |
| hdr_i | input | 8*HDR_BYTES | Assembled header region, byte 0 in top bits |
| hdr_len_i | input | $clog2(HDR_BYTES+1) | Total header length in bytes |
| delay_i | input | $clog2(HDR_WORDS+1) | Header word count, payload release delay |
| align_i | input | $clog2(BUS_BYTES) | Payload shift in bytes |
| pay_valid_i | input | 1 | Payload word offered |
| pay_data_i | input | 8*BUS_BYTES | Payload word |
| pay_last_i | input | 1 | Final payload word of the packet |
| pay_cnt_i | input | $clog2(BUS_BYTES+1) | Valid bytes of the final payload word |
| pay_ready_o | output | 1 | Delay line can take a word |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 8*BUS_BYTES | Output word |
| out_last_o | output | 1 | Final word of the packet |
| out_cnt_o | output | $clog2(BUS_BYTES+1) | Valid bytes in the output word |

## Verification
The bench builds the block with a 4-byte bus, a 16-byte header region and a 4-word delay line. With a 4-byte bus, every alignment offset, the spill into an extra trailing word and the case with no complete header word are all reached by headers of one to sixteen bytes. A 4-word delay line is small enough that a six-word payload offered before launch fills it and drives `pay_ready_o` low. Expected words come from a plain byte-queue model: header bytes followed by payload bytes, cut into bus words.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_MRG  = 2'd2,
    ST_TAIL = 2'd3
  } hs_state_e;
endpackage

// File: rtl/hs_delay_line.sv
module hs_delay_line #(
  parameter int B     = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(B + 1),
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = 8 * B + 1 + CW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_valid_i,
  input  logic [8*B-1:0] push_data_i,
  input  logic           push_last_i,
  input  logic [CW-1:0]  push_cnt_i,
  output logic           push_ready_o,
  input  logic           pop_i,
  output logic           head_valid_o,
  output logic [8*B-1:0] head_data_o,
  output logic           head_last_o,
  output logic [CW-1:0]  head_cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   level_q;
  logic          push, pop;

  assign push_ready_o = level_q != (AW+1)'(DEPTH);
  assign head_valid_o = level_q != '0;
  assign push = push_valid_i && push_ready_o;
  assign pop  = pop_i && head_valid_o;
  assign {head_data_o, head_last_o, head_cnt_o} = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= {push_data_i, push_last_i, push_cnt_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      level_q <= level_q + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  AST_HOLD_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_ready_o && !pop_i) |=> $stable(level_q)); // R8
endmodule

// File: rtl/hs_hdr_word.sv
module hs_hdr_word #(
  parameter int B         = 8,
  parameter int HDR_BYTES = 64,
  parameter int IW        = 4
) (
  input  logic [8*HDR_BYTES-1:0] hdr_i,
  input  logic [IW-1:0]          idx_i,
  output logic [8*B-1:0]         word_o
);
  always_comb begin
    word_o = '0;
    for (int j = 0; j < B; j++) begin
      if (int'(idx_i) * B + j < HDR_BYTES)
        word_o[8*(B-1-j) +: 8] = hdr_i[8*(HDR_BYTES-1-(int'(idx_i)*B+j)) +: 8];
    end
  end
endmodule

// File: rtl/hs_merge.sv
module hs_merge #(
  parameter int B   = 8,
  localparam int CW = $clog2(B + 1)
) (
  input  logic [8*B-1:0] carry_i,
  input  logic [CW-1:0]  ccnt_i,
  input  logic [8*B-1:0] data_i,
  output logic [8*B-1:0] merged_o,
  output logic [8*B-1:0] carry_o
);
  // merged: carry bytes then leading data bytes; carry_o: trailing data bytes
  always_comb begin
    merged_o = '0;
    carry_o  = '0;
    for (int j = 0; j < B; j++) begin
      if (j < int'(ccnt_i)) begin
        merged_o[8*(B-1-j) +: 8] = carry_i[8*(B-1-j) +: 8];
        carry_o[8*(B-1-j) +: 8]  = data_i[8*(int'(ccnt_i)-1-j) +: 8];
      end else begin
        merged_o[8*(B-1-j) +: 8] = data_i[8*(B-1-j+int'(ccnt_i)) +: 8];
      end
    end
  end
endmodule

// File: rtl/hdr_streamer.sv
module hdr_streamer
  import hs_pkg::*;
#(
  parameter int BUS_BYTES  = 8,
  parameter int HDR_BYTES  = 64,
  parameter int DEPTH      = 8,
  localparam int HDR_WORDS = (HDR_BYTES + BUS_BYTES - 1) / BUS_BYTES,
  localparam int CW        = $clog2(BUS_BYTES + 1),
  localparam int AW        = $clog2(BUS_BYTES),
  localparam int LW        = $clog2(HDR_BYTES + 1),
  localparam int DW        = $clog2(HDR_WORDS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  output logic                   start_ready_o,
  input  logic [8*HDR_BYTES-1:0] hdr_i,
  input  logic [LW-1:0]          hdr_len_i,
  input  logic [DW-1:0]          delay_i,
  input  logic [AW-1:0]          align_i,
  input  logic                   pay_valid_i,
  input  logic [8*BUS_BYTES-1:0] pay_data_i,
  input  logic                   pay_last_i,
  input  logic [CW-1:0]          pay_cnt_i,
  output logic                   pay_ready_o,
  output logic                   out_valid_o,
  output logic [8*BUS_BYTES-1:0] out_data_o,
  output logic                   out_last_o,
  output logic [CW-1:0]          out_cnt_o
);
  hs_state_e              st_q, st_d;
  logic [8*HDR_BYTES-1:0] hdr_q;
  logic [DW-1:0]          wcnt_q, wcnt_d, nfull_q, nfull_d;
  logic [CW-1:0]          ccnt_q, ccnt_d, tcnt_q, tcnt_d;
  logic [8*BUS_BYTES-1:0] carry_q, carry_d;
  logic                   first_q, first_d;

  logic                   head_valid, head_last, pop;
  logic [8*BUS_BYTES-1:0] head_data, hdr_word, carry_src, merged, carry_nx;
  logic [CW-1:0]          head_cnt;
  logic [CW:0]            tot;
  logic                   start_acc;

  hs_delay_line #(.B(BUS_BYTES), .DEPTH(DEPTH)) u_dline (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_valid_i (pay_valid_i),
    .push_data_i  (pay_data_i),
    .push_last_i  (pay_last_i),
    .push_cnt_i   (pay_cnt_i),
    .push_ready_o (pay_ready_o),
    .pop_i        (pop),
    .head_valid_o (head_valid),
    .head_data_o  (head_data),
    .head_last_o  (head_last),
    .head_cnt_o   (head_cnt)
  );

  hs_hdr_word #(.B(BUS_BYTES), .HDR_BYTES(HDR_BYTES), .IW(DW)) u_hword (
    .hdr_i  (hdr_q),
    .idx_i  (wcnt_q),
    .word_o (hdr_word)
  );

  assign carry_src = first_q ? hdr_word : carry_q;

  hs_merge #(.B(BUS_BYTES)) u_merge (
    .carry_i  (carry_src),
    .ccnt_i   (ccnt_q),
    .data_i   (head_data),
    .merged_o (merged),
    .carry_o  (carry_nx)
  );

  assign start_ready_o = st_q == ST_IDLE;
  assign start_acc     = start_i && start_ready_o;
  assign tot           = (CW+1)'(ccnt_q) + (CW+1)'(head_cnt);

  always_comb begin
    st_d        = st_q;
    wcnt_d      = wcnt_q;
    nfull_d     = nfull_q;
    ccnt_d      = ccnt_q;
    tcnt_d      = tcnt_q;
    carry_d     = carry_q;
    first_d     = first_q;
    pop         = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = '0;
    out_last_o  = 1'b0;
    out_cnt_o   = CW'(BUS_BYTES);
    unique case (st_q)
      ST_IDLE: if (start_acc) begin
        nfull_d = delay_i - DW'(align_i != '0);
        ccnt_d  = (align_i == '0) ? '0 : CW'(BUS_BYTES) - CW'(align_i);
        wcnt_d  = '0;
        first_d = 1'b1;
        st_d    = (nfull_d == '0) ? ST_MRG : ST_HDR;
      end
      ST_HDR: begin
        out_valid_o = 1'b1;
        out_data_o  = hdr_word;
        wcnt_d      = wcnt_q + 1'b1;
        if (wcnt_d == nfull_q) st_d = ST_MRG;
      end
      ST_MRG: if (head_valid) begin
        pop         = 1'b1;
        out_valid_o = 1'b1;
        out_data_o  = merged;
        carry_d     = carry_nx;
        first_d     = 1'b0;
        if (head_last) begin
          if (tot <= (CW+1)'(BUS_BYTES)) begin
            out_last_o = 1'b1;
            out_cnt_o  = CW'(tot);
            st_d       = ST_IDLE;
          end else begin
            tcnt_d = CW'(tot - (CW+1)'(BUS_BYTES));
            st_d   = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        out_valid_o = 1'b1;
        out_data_o  = carry_q;
        out_last_o  = 1'b1;
        out_cnt_o   = tcnt_q;
        st_d        = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      hdr_q   <= '0;
      wcnt_q  <= '0;
      nfull_q <= '0;
      ccnt_q  <= '0;
      tcnt_q  <= '0;
      carry_q <= '0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      wcnt_q  <= wcnt_d;
      nfull_q <= nfull_d;
      ccnt_q  <= ccnt_d;
      tcnt_q  <= tcnt_d;
      carry_q <= carry_d;
      first_q <= first_d;
      if (start_acc) hdr_q <= hdr_i;
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> !start_ready_o); // R1
  AST_CFG_CONSISTENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |-> (int'(delay_i) == (int'(hdr_len_i) + BUS_BYTES - 1) / BUS_BYTES) &&
                  (int'(align_i) == (BUS_BYTES - int'(hdr_len_i) % BUS_BYTES) % BUS_BYTES)); // R3
  AST_LAST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o) |-> (out_cnt_o != '0 && out_cnt_o <= CW'(BUS_BYTES))); // R6
  AST_MID_WORD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> out_cnt_o == CW'(BUS_BYTES)); // R6
  AST_SPILL_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && head_last && !out_last_o) |=> (out_valid_o && out_last_o)); // R7
endmodule

// File: tb/hdr_streamer_bench.sv
module hdr_streamer_bench;
  localparam int B  = 4;
  localparam int HB = 16;
  localparam int DP = 4;
  localparam int CW = $clog2(B + 1);
  localparam int LW = $clog2(HB + 1);
  localparam int DW = $clog2((HB + B - 1) / B + 1);
  localparam int AW = $clog2(B);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            start_ready;
  logic [8*HB-1:0] hdr = '0;
  logic [LW-1:0]   hlen = '0;
  logic [DW-1:0]   dly = '0;
  logic [AW-1:0]   aln = '0;
  logic            pvalid = 1'b0, plast = 1'b0, pready;
  logic [8*B-1:0]  pdata = '0;
  logic [CW-1:0]   pcnt = '0;
  logic            ovalid, olast;
  logic [8*B-1:0]  odata;
  logic [CW-1:0]   ocnt;

  int checks = 0, fails = 0;
  string cur_req = "R2";
  bit gapless = 1'b0, in_pkt = 1'b0;

  logic [8*B-1:0] exp_data[$];
  logic [CW-1:0]  exp_cnt[$];
  logic           exp_last[$];
  logic [8*B-1:0] pw_data[$];
  logic [CW-1:0]  pw_cnt[$];
  logic           pw_last[$];

  always #2 clk = ~clk;

  hdr_streamer #(.BUS_BYTES(B), .HDR_BYTES(HB), .DEPTH(DP)) u_hdr_streamer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_ready_o(start_ready),
    .hdr_i(hdr), .hdr_len_i(hlen), .delay_i(dly), .align_i(aln),
    .pay_valid_i(pvalid), .pay_data_i(pdata), .pay_last_i(plast), .pay_cnt_i(pcnt),
    .pay_ready_o(pready), .out_valid_o(ovalid), .out_data_o(odata),
    .out_last_o(olast), .out_cnt_o(ocnt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (ovalid) begin
        logic [8*B-1:0] ed;
        logic [CW-1:0] ec;
        logic el;
        bit ok;
        checks++;
        if (exp_data.size() == 0) begin
          fails++;
          $display("FAIL %s unexpected word: actual %h expected none", cur_req, odata);
        end else begin
          ed = exp_data.pop_front(); ec = exp_cnt.pop_front(); el = exp_last.pop_front();
          ok = (ocnt == ec) && (olast == el);
          for (int j = 0; j < B; j++)
            if (j < int'(ec) && odata[8*(B-1-j) +: 8] != ed[8*(B-1-j) +: 8]) ok = 1'b0;
          if (!ok) begin
            fails++;
            $display("FAIL %s word: actual %h cnt %0d last %0b expected %h cnt %0d last %0b",
                     cur_req, odata, ocnt, olast, ed, ec, el);
          end
        end
        in_pkt = !olast;
      end else if (in_pkt && gapless) begin
        checks++; fails++;
        $display("FAIL R5 bubble: actual valid 0 expected 1");
        in_pkt = 1'b0;
      end
    end
  end

  task automatic build(input int len, input int npay, input int lcnt);
    byte q[$];
    int nb;
    hdr = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < len; i++) q.push_back(hdr[8*(HB-1-i) +: 8]);
    for (int w = 0; w < npay; w++) begin
      logic [8*B-1:0] d;
      d = $urandom;
      pw_data.push_back(d);
      pw_last.push_back(w == npay - 1);
      pw_cnt.push_back(CW'((w == npay - 1) ? lcnt : B));
      for (int j = 0; j < ((w == npay - 1) ? lcnt : B); j++) q.push_back(d[8*(B-1-j) +: 8]);
    end
    nb = q.size();
    for (int k = 0; k < nb; k += B) begin
      logic [8*B-1:0] d;
      int c;
      d = '0;
      c = (nb - k < B) ? nb - k : B;
      for (int j = 0; j < c; j++) d[8*(B-1-j) +: 8] = q[k + j];
      exp_data.push_back(d);
      exp_cnt.push_back(CW'(c));
      exp_last.push_back(k + B >= nb);
    end
  endtask

  task automatic drive_payload();
    while (pw_data.size() != 0) begin
      @(negedge clk);
      pvalid = 1'b1;
      pdata = pw_data.pop_front(); plast = pw_last.pop_front(); pcnt = pw_cnt.pop_front();
      while (!pready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    pvalid = 1'b0;
  endtask

  task automatic drive_start(input int len, input bit junk);
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start = 1'b1;
    hlen = LW'(len);
    dly = DW'((len + B - 1) / B);
    aln = AW'((B - len % B) % B);
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      // R1: strobe while busy with other fields
      hdr = ~hdr; hlen = LW'(1); dly = DW'(1); aln = AW'(B - 1);
      @(posedge clk);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while ((exp_data.size() != 0 || in_pkt) && t < 200) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    check(exp_data.size() == 0, cur_req, "words left", 64'(exp_data.size()), 0);
  endtask

  task automatic run_pkt(input string req, input int len, input int npay,
                         input int lcnt, input bit junk);
    cur_req = req;
    build(len, npay, lcnt);
    gapless = 1'b1;
    drive_payload();
    drive_start(len, junk);
    wait_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!ovalid, "R9", "out_valid", 64'(ovalid), 0);
    check(start_ready, "R9", "start_ready", 64'(start_ready), 1);
    check(pready, "R9", "pay_ready", 64'(pready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    run_pkt("R2", 8, 3, 4, 1'b0);   // aligned header, R3
    run_pkt("R4", 5, 2, 2, 1'b0);   // one header tail byte
    run_pkt("R7", 6, 1, 4, 1'b0);   // spill into extra word
    run_pkt("R4", 3, 3, 1, 1'b0);   // no complete header word
    run_pkt("R7", 7, 2, 3, 1'b0);   // carry 3 + 3 > 4
    run_pkt("R6", 16, 1, 1, 1'b0);  // full header region, single byte payload
    run_pkt("R5", 9, 4, 2, 1'b0);   // shifted payload stream
    run_pkt("R1", 10, 3, 3, 1'b1);  // strobe while busy is ignored

    // R8: fill delay line before launch
    cur_req = "R8";
    build(2, 6, 3);
    gapless = 1'b0;
    fork
      drive_payload();
      begin
        repeat (10) @(negedge clk);
        check(!pready, "R8", "pay_ready when full", 64'(pready), 0);
        check(!ovalid, "R8", "no output before start", 64'(ovalid), 0);
        drive_start(2, 1'b0);
      end
    join
    wait_done();

    for (int n = 0; n < 24; n++) begin
      int len, np, lc;
      len = 1 + int'($urandom_range(HB - 1));
      np  = 1 + int'($urandom_range(DP - 1));
      lc  = 1 + int'($urandom_range(B - 1));
      run_pkt("R5", len, np, lc, 1'b0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule